// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface and brings a freshly powered memory to an operational state. After reset it drives only NOP commands. It waits for a clock-stable indication, then counts a long power-up wait. It then issues, in a fixed order, a precharge of all banks, two auto refreshes and a mode register load. Each command lasts one cycle and is followed by its own parameterised NOP wait. When the wait after the mode load has run out, it raises `init_done`, which stays high until the next reset.

The command is driven on the four active-low pins (chip select, row strobe, column strobe, write enable). The address bus carries A10 high during the precharge and the mode word during the mode load. The bank address pins stay at zero. All waits are counted in clock cycles by a single down-counter.

The states are: `ST_WAIT_CLK` (idle until clock stable), `ST_PWRUP` (power-up wait), `ST_PRE` (precharge all), `ST_TRP` (precharge wait), `ST_REF1` (first refresh), `ST_TRFC1` (first refresh wait), `ST_REF2` (second refresh), `ST_TRFC2` (second refresh wait), `ST_LMR` (mode load), `ST_TMRD` (mode settle wait) and `ST_DONE`. The transitions run in that order:

| From | To | Condition |
|------|----|-----------|
| `ST_WAIT_CLK` | `ST_PWRUP` | `clk_stable` is sampled high |
| each wait state | next command state | its counter reaches zero |
| each command state | its wait state | always, after one cycle |

`ST_DONE` is terminal. Reset returns the sequencer to `ST_WAIT_CLK` from any state.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, the outputs are a NOP, `init_done` is low, and `addr` and `ba` are zero. NOP means {cs_n,ras_n,cas_n,we_n} = 0111.
- R2: Until `clk_stable` has been sampled high at a rising edge, the block drives only NOP, with `addr` equal to 0.
- R3: After the edge at which `clk_stable` is first sampled high, exactly T_PWRUP NOP cycles follow, and then the precharge command.
- R4: The precharge command is encoded 0010, with `addr[10]`=1, every other address bit 0 and `ba`=0.
- R5: After the precharge, exactly T_RP NOP cycles follow, and then the first auto refresh, encoded 0001 with `addr`=0 and `ba`=0.
- R6: After each auto refresh, exactly T_RFC NOP cycles follow. The first wait ends in the second auto refresh and the second wait ends in the mode load.
- R7: The mode load is encoded 0000 with `ba`=0 and `addr[9:0]` equal to `mode_word[9:0]`, sampled in that same cycle.
- R8: `addr[11:10]` is 0 during the mode load even when `mode_word[11:10]` is non-zero.
- R9: After the mode load, exactly T_MRD NOP cycles follow. `init_done` then rises, and it stays high with NOP driven until reset.
- R10: Every non-NOP command lasts exactly one cycle.
- R11: A reset asserted in the middle of the sequence returns the block to waiting for `clk_stable`, with NOP driven and `init_done` low. The whole sequence then repeats.
- R12: Once the power-up wait has started, `clk_stable` going low has no effect on the command sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_stable | input | 1 | High once the memory clock is stable |
| mode_word | input | ADDR_W (12) | Mode register value: burst length [2:0], burst type [3], CAS latency [6:4], operating mode [8:7], write burst mode [9] |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W (12) | Address bus |
| ba | output | BA_W (2) | Bank address |
| init_done | output | 1 | High once initialization has completed |

## Verification
The assertions assume that reset is synchronous and is held for at least one edge. They also assume that `mode_word` is stable in the cycle the mode load is issued, and that every wait parameter is at least 1.

The bench changes `mode_word` and `clk_stable` only shortly after a rising edge. It holds `mode_word` constant across each run. It drops `clk_stable` only after the power-up wait has begun, and it does so on purpose.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [3:0] {
        ST_WAIT_CLK,
        ST_PWRUP,
        ST_PRE,
        ST_TRP,
        ST_REF1,
        ST_TRFC1,
        ST_REF2,
        ST_TRFC2,
        ST_LMR,
        ST_TMRD,
        ST_DONE
    } init_state_t;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRE,
        CMD_REF,
        CMD_LMR
    } init_cmd_t;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] PINS_NOP = 4'b0111;
    localparam logic [3:0] PINS_PRE = 4'b0010;
    localparam logic [3:0] PINS_REF = 4'b0001;
    localparam logic [3:0] PINS_LMR = 4'b0000;

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_enc.sv
module sdram_init_enc
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BA_W      = 2,
    parameter int MODE_USED = 10,
    parameter int PRE_BIT   = 10
) (
    input  init_cmd_t         cmd,
    input  logic [ADDR_W-1:0] mode_word,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba
);

    logic [3:0] pins;

    always_comb begin
        unique case (cmd)
            CMD_NOP: pins = PINS_NOP;
            CMD_PRE: pins = PINS_PRE;
            CMD_REF: pins = PINS_REF;
            CMD_LMR: pins = PINS_LMR;
            default: pins = PINS_NOP;
        endcase
    end

    assign {cs_n, ras_n, cas_n, we_n} = pins;
    assign ba = '0;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_addr
        if (i < MODE_USED) begin : g_mode
            if (i == PRE_BIT) begin : g_pre
                assign addr[i] = (cmd == CMD_PRE) || ((cmd == CMD_LMR) && mode_word[i]);
            end else begin : g_plain
                assign addr[i] = (cmd == CMD_LMR) && mode_word[i];
            end
        end else begin : g_rsvd
            if (i == PRE_BIT) begin : g_pre
                assign addr[i] = (cmd == CMD_PRE);
            end else begin : g_zero
                assign addr[i] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int BA_W    = 2,
    parameter int T_PWRUP = 12500,
    parameter int T_RP    = 3,
    parameter int T_RFC   = 8,
    parameter int T_MRD   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_stable,
    input  logic [ADDR_W-1:0] mode_word,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              init_done
);

    localparam int MAX_A = (T_PWRUP > T_RFC) ? T_PWRUP : T_RFC;
    localparam int MAX_B = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_T + 1);

    localparam logic [CNT_W-1:0] LD_PWRUP = CNT_W'(T_PWRUP - 1);
    localparam logic [CNT_W-1:0] LD_RP    = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] LD_RFC   = CNT_W'(T_RFC - 1);
    localparam logic [CNT_W-1:0] LD_MRD   = CNT_W'(T_MRD - 1);

    init_state_t      state_q, state_d;
    init_cmd_t        cmd;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT_CLK;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and wait loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_WAIT_CLK: if (clk_stable) begin
                state_d  = ST_PWRUP;
                tmr_load = 1'b1;
                tmr_val  = LD_PWRUP;
            end
            ST_PWRUP: if (tmr_expired) state_d = ST_PRE;
            ST_PRE: begin
                state_d  = ST_TRP;
                tmr_load = 1'b1;
                tmr_val  = LD_RP;
            end
            ST_TRP: if (tmr_expired) state_d = ST_REF1;
            ST_REF1: begin
                state_d  = ST_TRFC1;
                tmr_load = 1'b1;
                tmr_val  = LD_RFC;
            end
            ST_TRFC1: if (tmr_expired) state_d = ST_REF2;
            ST_REF2: begin
                state_d  = ST_TRFC2;
                tmr_load = 1'b1;
                tmr_val  = LD_RFC;
            end
            ST_TRFC2: if (tmr_expired) state_d = ST_LMR;
            ST_LMR: begin
                state_d  = ST_TMRD;
                tmr_load = 1'b1;
                tmr_val  = LD_MRD;
            end
            ST_TMRD: if (tmr_expired) state_d = ST_DONE;
            ST_DONE: state_d = ST_DONE;
            default: state_d = ST_WAIT_CLK;
        endcase
    end

    // outputs
    always_comb begin
        cmd       = CMD_NOP;
        init_done = 1'b0;
        unique case (state_q)
            ST_PRE:  cmd = CMD_PRE;
            ST_REF1: cmd = CMD_REF;
            ST_REF2: cmd = CMD_REF;
            ST_LMR:  cmd = CMD_LMR;
            ST_DONE: init_done = 1'b1;
            default: cmd = CMD_NOP;
        endcase
    end

    sdram_init_timer #(
        .CNT_W(CNT_W)
    ) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sdram_init_enc #(
        .ADDR_W    (ADDR_W),
        .BA_W      (BA_W),
        .MODE_USED (10),
        .PRE_BIT   (10)
    ) enc_i (
        .cmd       (cmd),
        .mode_word (mode_word),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .addr      (addr),
        .ba        (ba)
    );

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
    parameter int ADDR_W  = 12,
    parameter int BA_W    = 2,
    parameter int T_PWRUP = 12500,
    parameter int T_RP    = 3,
    parameter int T_RFC   = 8,
    parameter int T_MRD   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              clk_stable,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [BA_W-1:0]   ba,
    input logic              init_done
);

    logic [3:0] pins;
    assign pins = {cs_n, ras_n, cas_n, we_n};

    logic seen_stable;
    int   nop_run;
    int   refs;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_stable <= 1'b0;
            nop_run     <= 0;
            refs        <= 0;
        end else begin
            if (clk_stable) seen_stable <= 1'b1;
            if (pins == 4'b0111) begin
                if (nop_run < 32'h7fff_ffff) nop_run <= nop_run + 1;
            end else begin
                nop_run <= 0;
            end
            if (pins == 4'b0001) refs <= refs + 1;
        end
    end

    p_nop_before_stable_r2: assert property (@(posedge clk) disable iff (rst)
        !seen_stable |-> pins == 4'b0111);

    p_pre_gap_r3: assert property (@(posedge clk) disable iff (rst)
        pins == 4'b0010 |-> nop_run >= T_PWRUP);

    p_pre_a10_r4: assert property (@(posedge clk) disable iff (rst)
        pins == 4'b0010 |-> addr[10] && ba == '0);

    p_ref1_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0001 && refs == 0) |-> nop_run == T_RP);

    p_ref2_gap_r6: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0001 && refs == 1) |-> nop_run == T_RFC);

    p_lmr_gap_r6: assert property (@(posedge clk) disable iff (rst)
        pins == 4'b0000 |-> nop_run == T_RFC && refs == 2);

    p_lmr_rsvd_r8: assert property (@(posedge clk) disable iff (rst)
        pins == 4'b0000 |-> addr[ADDR_W-1:10] == '0 && ba == '0);

    p_done_gap_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> nop_run == T_MRD);

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    p_done_nop_r9: assert property (@(posedge clk) disable iff (rst)
        init_done |-> pins == 4'b0111);

    p_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
        pins != 4'b0111 |=> pins == 4'b0111);

endmodule

bind sdram_init_seq sdram_init_chk #(
    .ADDR_W  (ADDR_W),
    .BA_W    (BA_W),
    .T_PWRUP (T_PWRUP),
    .T_RP    (T_RP),
    .T_RFC   (T_RFC),
    .T_MRD   (T_MRD)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .clk_stable (clk_stable),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .addr       (addr),
    .ba         (ba),
    .init_done  (init_done)
);

// File: tb/sdram_init_seq_tb_top.sv
module sdram_init_seq_tb_top;

    localparam int ADDR_W  = 12;
    localparam int BA_W    = 2;
    localparam int T_PWRUP = 20;
    localparam int T_RP    = 3;
    localparam int T_RFC   = 5;
    localparam int T_MRD   = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clk_stable = 1'b0;
    logic [ADDR_W-1:0] mode_word = '0;
    logic              cs_n, ras_n, cas_n, we_n;
    logic [ADDR_W-1:0] addr;
    logic [BA_W-1:0]   ba;
    logic              init_done;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    sdram_init_seq #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .T_PWRUP(T_PWRUP),
        .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)
    ) dut_i (
        .clk(clk), .rst(rst), .clk_stable(clk_stable), .mode_word(mode_word),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .ba(ba), .init_done(init_done)
    );

    typedef struct {
        logic [3:0] pins;
        logic       done;
        int         tag;
    } exp_t;

    exp_t  q[$];
    exp_t  cur;
    logic  seen;
    string ovr = "";

    function automatic string tagname(int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            9: return "R9";
            default: return "R?";
        endcase
    endfunction

    function automatic exp_t mk(logic [3:0] p, logic d, int t);
        exp_t e;
        e.pins = p;
        e.done = d;
        e.tag  = t;
        return e;
    endfunction

    task automatic build_seq();
        q.delete();
        for (int i = 0; i < T_PWRUP; i++) q.push_back(mk(4'b0111, 1'b0, 3));
        q.push_back(mk(4'b0010, 1'b0, 4));
        for (int i = 0; i < T_RP; i++) q.push_back(mk(4'b0111, 1'b0, 5));
        q.push_back(mk(4'b0001, 1'b0, 5));
        for (int i = 0; i < T_RFC; i++) q.push_back(mk(4'b0111, 1'b0, 6));
        q.push_back(mk(4'b0001, 1'b0, 6));
        for (int i = 0; i < T_RFC; i++) q.push_back(mk(4'b0111, 1'b0, 6));
        q.push_back(mk(4'b0000, 1'b0, 7));
        for (int i = 0; i < T_MRD; i++) q.push_back(mk(4'b0111, 1'b0, 9));
    endtask

    // reference model: advances one step per rising edge
    always @(posedge clk) begin
        if (rst) begin
            seen = 1'b0;
            q.delete();
            cur = mk(4'b0111, 1'b0, 1);
        end else if (!seen && clk_stable) begin
            seen = 1'b1;
            build_seq();
            cur = q.pop_front();
        end else if (seen) begin
            if (q.size() > 0) cur = q.pop_front();
            else cur = mk(4'b0111, 1'b1, 9);
        end else begin
            cur = mk(4'b0111, 1'b0, 2);
        end
    end

    logic [3:0] prev_pins = 4'b0111;

    // compare on every falling edge
    always @(negedge clk) begin
        logic [3:0]        act;
        logic [ADDR_W-1:0] exp_addr;
        string             t;
        act = {cs_n, ras_n, cas_n, we_n};
        t = (ovr != "") ? ovr : tagname(cur.tag);
        if (cur.pins == 4'b0010)      exp_addr = 12'h400;
        else if (cur.pins == 4'b0000) exp_addr = {2'b00, mode_word[9:0]};
        else                          exp_addr = '0;
        if (cur.pins == 4'b0000 && mode_word[11:10] != 2'b00) t = "R8";

        total++;
        if (act !== cur.pins) begin
            bad++;
            $display("FAIL %s cmd act=%b exp=%b t=%0t", t, act, cur.pins, $time);
        end
        total++;
        if (init_done !== cur.done) begin
            bad++;
            $display("FAIL %s init_done act=%b exp=%b t=%0t", t, init_done, cur.done, $time);
        end
        total++;
        if (addr !== exp_addr || ba !== '0) begin
            bad++;
            $display("FAIL %s addr/ba act=%h/%0d exp=%h/0 t=%0t", t, addr, ba, exp_addr, $time);
        end
        // R10: a command never repeats in consecutive cycles
        if (!rst) begin
            total++;
            if (act != 4'b0111 && act == prev_pins) begin
                bad++;
                $display("FAIL R10 repeated cmd act=%b exp=0111 t=%0t", act, $time);
            end
        end
        prev_pins = act;
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    localparam int SEQ_LEN = T_PWRUP + T_RP + 2 * T_RFC + T_MRD + 4;

    initial begin : stim
        // R1: reset state
        rst = 1'b1;
        step(3);
        rst = 1'b0;
        // R2: clock not yet stable
        step(10);
        // R3..R9 with reserved mode bits set (R8)
        mode_word  = 12'hF5A;
        clk_stable = 1'b1;
        step(5);
        // R12: clk_stable drops during power-up wait
        ovr = "R12";
        clk_stable = 1'b0;
        step(4);
        ovr = "";
        step(SEQ_LEN);
        step(10);
        // R11: reset in mid-sequence
        clk_stable = 1'b1;
        mode_word  = 12'h032;
        rst = 1'b1;
        step(1);
        rst = 1'b0;
        clk_stable = 1'b0;
        step(1);
        ovr = "R11";
        step(4);
        ovr = "";
        clk_stable = 1'b1;
        step(T_PWRUP + T_RP + 3);
        ovr = "R11";
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        clk_stable = 1'b0;
        step(3);
        ovr = "";
        // full run with a plain mode word
        mode_word  = 12'h237;
        clk_stable = 1'b1;
        step(SEQ_LEN + 8);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule